// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a down-counting watchdog protected by a rolling key. Software drives it with single-cycle control writes. Each write carries a start value for the counter, a start/stop command and a 7-bit key. A write is accepted only when its key is the bitwise complement of the key in the last accepted write. A stray or runaway write is therefore very unlikely to kick or stop the watchdog by chance. Issuing start while the watchdog already runs reloads the counter, so starting and kicking are one operation.

A free-running prescaler divides the system clock by a power of two and produces a one-cycle tick. With the default width of 17 bits, a 100 MHz clock gives about 763 ticks per second. While the watchdog runs, each tick lowers the count by one. When the count shows 1, the block raises a non-maskable interrupt request. When the count shows 0, it raises a chip reset request. Both requests are sticky levels that only a system reset clears. The count, the running state and a sticky key-error flag can be read back at the ports.

Top module: `kwdt_top`

## Requirements
- R1: After synchronous reset, `running`, `count`, `nmi_req`, `rst_req` and `key_err` are all zero.
- R2: Until the first write is accepted, a start write (`wr_cmd`=1) is accepted with any key. A stop write (`wr_cmd`=0) in that state is rejected.
- R3: After a write is accepted, a later write is accepted only if its key equals the last accepted key XOR 7'h7F. An accepted start loads `wr_cnt` into `count` and sets `running`, even when the watchdog is already running.
- R4: A rejected write leaves `count`, `running` and the key reference unchanged. It sets `key_err`, which stays set until reset.
- R5: While running, `count` drops by one every 2^PRESC_W cycles and holds at 0. The first drop comes exactly 2^PRESC_W cycles after an accepted start, because the prescaler restarts on it.
- R6: An accepted stop clears `running`. While stopped, `count` holds its value.
- R7: `nmi_req` rises in the cycle after `count` shows 1 while running, and then stays high.
- R8: `rst_req` rises in the cycle after `count` shows 0 while running, and then stays high. Starting with a count of 0 raises `rst_req` one cycle later without raising `nmi_req`.
- R9: Once raised, neither request is cleared by a later stop or start write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle control write strobe |
| wr_cnt | input | CNT_W | Start value for the counter |
| wr_cmd | input | 1 | 1 = start/kick, 0 = stop |
| wr_key | input | 7 | Key carried by the write |
| running | output | 1 | Watchdog is counting |
| count | output | CNT_W | Current counter value |
| key_err | output | 1 | Sticky flag: a write was rejected |
| nmi_req | output | 1 | Sticky non-maskable interrupt request |
| rst_req | output | 1 | Sticky chip reset request |

## Verification
The bench builds the block with CNT_W=8 and PRESC_W=3, so a tick comes every 8 cycles. At that rate, full countdowns into the interrupt and reset requests take only a few dozen cycles. The same setting makes the exact cycle of each decrement, including the prescaler restart on a mid-period kick, easy to observe. The key sequence, rejected writes, stop-before-start and the sticky requests do not depend on the prescaler width.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
    localparam int KEY_W = 7;
    localparam logic [KEY_W-1:0] KEY_FLIP = '1;

    typedef enum logic {
        WD_STOP  = 1'b0,
        WD_START = 1'b1
    } wd_cmd_e;

    typedef struct packed {
        logic do_start;
        logic do_stop;
    } gate_res_t;

    function automatic logic [KEY_W-1:0] next_key(input logic [KEY_W-1:0] k);
        return k ^ KEY_FLIP;
    endfunction
endpackage

// File: rtl/kwdt_prescaler.sv
module kwdt_prescaler #(
    parameter int PRESC_W = 17
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic tick
);
    logic [PRESC_W-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst || restart) div_q <= '0;
        else                div_q <= div_q + 1'b1;
    end

    assign tick = &div_q;
endmodule

// File: rtl/kwdt_keygate.sv
module kwdt_keygate
    import kwdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  wd_cmd_e          wr_cmd,
    input  logic [KEY_W-1:0] wr_key,
    output gate_res_t        res,
    output logic             key_err
);
    logic             have_ref;
    logic [KEY_W-1:0] ref_key;
    logic             key_ok;
    logic             accept;

    always_comb begin
        if (have_ref) key_ok = (wr_key == next_key(ref_key));
        else          key_ok = (wr_cmd == WD_START);
        accept       = wr_en && key_ok;
        res.do_start = accept && (wr_cmd == WD_START);
        res.do_stop  = accept && (wr_cmd == WD_STOP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            have_ref <= 1'b0;
            ref_key  <= '0;
            key_err  <= 1'b0;
        end else begin
            if (accept) begin
                have_ref <= 1'b1;
                ref_key  <= wr_key;
            end
            if (wr_en && !key_ok) key_err <= 1'b1;
        end
    end
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             do_start,
    input  logic             do_stop,
    input  logic             tick,
    input  logic [CNT_W-1:0] load_val,
    output logic             running,
    output logic [CNT_W-1:0] count,
    output logic             nmi_req,
    output logic             rst_req
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            count   <= '0;
            nmi_req <= 1'b0;
            rst_req <= 1'b0;
        end else begin
            if (running && count == ONE) nmi_req <= 1'b1;
            if (running && count == '0)  rst_req <= 1'b1;
            if (do_start) begin
                count   <= load_val;
                running <= 1'b1;
            end else if (do_stop) begin
                running <= 1'b0;
            end else if (running && tick && count != '0) begin
                count <= count - ONE;
            end
        end
    end
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
    import kwdt_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int PRESC_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_cnt,
    input  logic             wr_cmd,
    input  logic [KEY_W-1:0] wr_key,
    output logic             running,
    output logic [CNT_W-1:0] count,
    output logic             key_err,
    output logic             nmi_req,
    output logic             rst_req
);
    gate_res_t gate;
    logic      tick;

    kwdt_keygate u_gate (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_cmd  (wd_cmd_e'(wr_cmd)),
        .wr_key  (wr_key),
        .res     (gate),
        .key_err (key_err)
    );

    kwdt_prescaler #(.PRESC_W(PRESC_W)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .restart (gate.do_start),
        .tick    (tick)
    );

    kwdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .do_start (gate.do_start),
        .do_stop  (gate.do_stop),
        .tick     (tick),
        .load_val (wr_cnt),
        .running  (running),
        .count    (count),
        .nmi_req  (nmi_req),
        .rst_req  (rst_req)
    );
endmodule

// File: rtl/kwdt_checker.sv
module kwdt_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             running,
    input logic [CNT_W-1:0] count,
    input logic             key_err,
    input logic             nmi_req,
    input logic             rst_req
);
    assert_err_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        key_err |=> key_err);

    assert_step_R5: assert property (@(posedge clk) disable iff (rst)
        (running && !wr_en) |=>
            (count == $past(count) || count == $past(count) - CNT_W'(1)));

    assert_hold_stopped_R6: assert property (@(posedge clk) disable iff (rst)
        (!running && !wr_en) |=> $stable(count));

    assert_nmi_fires_R7: assert property (@(posedge clk) disable iff (rst)
        (running && count == CNT_W'(1)) |=> nmi_req);

    assert_rst_fires_R8: assert property (@(posedge clk) disable iff (rst)
        (running && count == '0) |=> rst_req);

    assert_nmi_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        nmi_req |=> nmi_req);

    assert_rst_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> rst_req);
endmodule

bind kwdt_top kwdt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .running (running),
    .count   (count),
    .key_err (key_err),
    .nmi_req (nmi_req),
    .rst_req (rst_req)
);

// File: tb/tb_kwdt_top.sv
module tb_kwdt_top;
    localparam int CNT_W   = 8;
    localparam int PRESC_W = 3;
    localparam int TPER    = 1 << PRESC_W;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic [CNT_W-1:0] wr_cnt = '0;
    logic             wr_cmd = 1'b0;
    logic [6:0]       wr_key = '0;
    logic             running, key_err, nmi_req, rst_req;
    logic [CNT_W-1:0] count;

    int n_chk = 0;
    int n_bad = 0;

    kwdt_top #(.CNT_W(CNT_W), .PRESC_W(PRESC_W)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_cnt(wr_cnt),
        .wr_cmd(wr_cmd), .wr_key(wr_key), .running(running),
        .count(count), .key_err(key_err), .nmi_req(nmi_req),
        .rst_req(rst_req)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        wait_n(2);
        rst = 1'b0;
    endtask

    task automatic wr(input int cnt, input bit cmd, input int key);
        wr_en  = 1'b1;
        wr_cnt = CNT_W'(cnt);
        wr_cmd = cmd;
        wr_key = 7'(key);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R1 running", running, 0);
        check("R1 count", count, 0);
        check("R1 nmi", nmi_req, 0);
        check("R1 rst_req", rst_req, 0);
        check("R1 key_err", key_err, 0);
    endtask

    task automatic t_first_cmd();
        do_reset();
        wr(12, 1'b0, 7'h11);
        check("R2 stop first rejected running", running, 0);
        check("R2 stop first sets err", key_err, 1);
        wr(12, 1'b1, 7'h11);
        check("R2 start any key running", running, 1);
        check("R2 start any key count", count, 12);
    endtask

    task automatic t_countdown();
        do_reset();
        wr(3, 1'b1, 7'h2A);
        check("R3 load", count, 3);
        wait_n(TPER - 1);
        check("R5 before first tick", count, 3);
        wait_n(1);
        check("R5 first decrement", count, 2);
        wait_n(TPER);
        check("R7 count one", count, 1);
        check("R7 nmi not yet", nmi_req, 0);
        wait_n(1);
        check("R7 nmi raised", nmi_req, 1);
        check("R8 rst not yet", rst_req, 0);
        wait_n(TPER - 1);
        check("R8 count zero", count, 0);
        check("R8 rst before", rst_req, 0);
        wait_n(1);
        check("R8 rst raised", rst_req, 1);
        wait_n(TPER);
        check("R5 hold at zero", count, 0);
        check("R7 nmi sticky", nmi_req, 1);
    endtask

    task automatic t_kick();
        do_reset();
        wr(10, 1'b1, 7'h2A);
        wait_n(5);
        wr(20, 1'b1, 7'h55);
        check("R3 kick reload", count, 20);
        check("R3 kick accepted err", key_err, 0);
        wait_n(TPER - 1);
        check("R5 prescaler restart hold", count, 20);
        wait_n(1);
        check("R5 prescaler restart step", count, 19);
        wr(20, 1'b1, 7'h2A);
        check("R3 second kick", count, 20);
    endtask

    task automatic t_bad_key();
        do_reset();
        wr(50, 1'b1, 7'h2A);
        wr(5, 1'b1, 7'h2A);
        check("R4 bad key count", count, 50);
        check("R4 bad key running", running, 1);
        check("R4 bad key err", key_err, 1);
        wr(5, 1'b0, 7'h55);
        check("R4 ref unchanged stop ok", running, 0);
        check("R4 err sticky", key_err, 1);
    endtask

    task automatic t_stop();
        do_reset();
        wr(9, 1'b1, 7'h2A);
        wr(0, 1'b0, 7'h55);
        check("R6 stopped", running, 0);
        check("R6 count kept", count, 9);
        wait_n(3 * TPER);
        check("R6 count held", count, 9);
        check("R6 no nmi", nmi_req, 0);
        wr(4, 1'b1, 7'h2A);
        check("R3 restart after stop", running, 1);
        check("R3 restart count", count, 4);
    endtask

    task automatic t_zero_start();
        do_reset();
        wr(0, 1'b1, 7'h03);
        check("R8 zero start rst before", rst_req, 0);
        wait_n(1);
        check("R8 zero start rst", rst_req, 1);
        check("R8 zero start no nmi", nmi_req, 0);
    endtask

    task automatic t_sticky();
        do_reset();
        wr(1, 1'b1, 7'h00);
        wait_n(1);
        check("R7 nmi from one", nmi_req, 1);
        wr(0, 1'b0, 7'h7F);
        check("R9 stop accepted", running, 0);
        check("R9 nmi kept after stop", nmi_req, 1);
        wr(30, 1'b1, 7'h00);
        wait_n(2);
        check("R9 nmi kept after start", nmi_req, 1);
        check("R9 running again", running, 1);
    endtask

    initial begin
        #(10 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait_n(1);
        t_reset_state();
        t_first_cmd();
        t_countdown();
        t_kick();
        t_bad_key();
        t_stop();
        t_zero_start();
        t_sticky();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule